// File: doc/BRIEF.md
# Earliest Free Bank Mask Generator

This block looks at a DRAM controller's request queue and its per-bank ready times and reports which banks will be free soonest among the banks that actually have work waiting. Each queue entry gives a rank number, a bank number and a valid bit. The block maps every valid entry to a flat bank index and ORs them into a per-bank waiting vector. It then finds the smallest ready time among the waiting banks. The result is a multi-hot mask with one bit for every waiting bank that reaches that minimum, together with the minimum time itself.

A scheduler uses the mask to prefer requests whose bank frees up first when no row hit is available. Banks with nothing queued never appear in the mask, however early they free up. Ties are reported in full rather than broken, so the selection policy downstream decides among them. A parameter sets the result latency, from purely combinational to a registered pipeline. Another parameter chooses between an ordered linear scan and a two-pass tree. Both give the same result.

Top module: `efb_earliest_bank_mask`

## Requirements
- R1: A bank counts as waiting only when at least one queue entry with its `q_valid` bit set targets it. Entries whose valid bit is clear have no effect on the mask or the minimum.
- R2: Entry e takes its rank from `q_rank[e*RANK_W +: RANK_W]` and its bank from `q_bank[e*BANK_W +: BANK_W]`. Its flat index is rank * BANKS_PER_RANK + bank, and that index is the bit position in `out_mask` and the slot `bank_ready_time[idx*TIME_W +: TIME_W]`.
- R3: Every waiting bank whose ready time equals the minimum has its mask bit set, so ties give several set bits. No other bit is set.
- R4: `out_min` equals the smallest ready time among the waiting banks, and no waiting bank has a smaller ready time.
- R5: When no bank is waiting, `out_mask` is all zeros and `out_min` is all ones (the largest representable time).
- R6: Mask bits at positions NUM_BANKS and above are always zero. The bank count is limited to 64.
- R7: `out_valid` repeats `in_valid` exactly LATENCY cycles later, and the result computed from that cycle's inputs appears with it. With LATENCY 0 the result appears in the same cycle.
- R8: During reset `out_valid` is 0, `out_mask` is zero and `out_min` is all ones. With LATENCY at least 1, the outputs hold their last result in every cycle where `out_valid` is low.
- R9: The ready time of a bank with no valid entry has no effect, even when it is smaller than every waiting bank's time.
- R10: The linear scan variant (SCAN_STYLE 0) and the tree variant (SCAN_STYLE 1) produce identical masks and minimums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs this cycle form a request for a result |
| bank_ready_time | input | NUM_BANKS*TIME_W | Ready time per flat bank index |
| q_valid | input | QUEUE_DEPTH | Valid bit per queue entry |
| q_rank | input | QUEUE_DEPTH*RANK_W | Rank field per queue entry |
| q_bank | input | QUEUE_DEPTH*BANK_W | Bank field per queue entry |
| out_valid | output | 1 | Result valid |
| out_mask | output | 64 | Multi-hot mask of the earliest free waiting banks |
| out_min | output | TIME_W | Minimum ready time among waiting banks |

## Verification
The assertions check the scan result on every cycle, bank by bank:
- a set mask bit always belongs to a waiting bank whose time equals the reported minimum;
- no waiting bank lies below that minimum, and every waiting bank at the minimum is in the mask;
- an empty waiting set gives a zero mask and an all-ones minimum.

They also check the upper mask bits, the valid latency, and that the outputs hold when no result arrives.

Only the bench scenarios show the rest. One is the correct rank and bank to bit mapping. Another is that a non-waiting bank with an earlier time is skipped. A third is that both scan variants agree on identical inputs, including duplicate entries and ties at the largest time value.

// File: rtl/efb_pkg.sv
package efb_pkg;

  // Width of the bank mask seen at the block boundary.
  localparam int unsigned EFB_MASK_W = 64;

  // Flat bank number from a rank and a bank within that rank.
  function automatic int unsigned efb_flat_index(input int unsigned rank_i,
                                                 input int unsigned bank_i,
                                                 input int unsigned banks_per_rank);
    return rank_i * banks_per_rank + bank_i;
  endfunction

  // Number of bits needed to carry an index below n (at least one).
  function automatic int unsigned efb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/efb_waiting_map.sv
module efb_waiting_map #(
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 8,
  parameter int unsigned QUEUE_DEPTH    = 8,
  parameter int unsigned RANK_W         = 1,
  parameter int unsigned BANK_W         = 3,
  localparam int unsigned NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK
) (
  input  logic [QUEUE_DEPTH-1:0]        q_valid,
  input  logic [QUEUE_DEPTH*RANK_W-1:0] q_rank,
  input  logic [QUEUE_DEPTH*BANK_W-1:0] q_bank,
  output logic [NUM_BANKS-1:0]          bank_waiting
);
  import efb_pkg::*;

  // Flat index per entry, with an in-range flag for non power-of-two shapes.
  int unsigned entry_idx [QUEUE_DEPTH];
  logic [QUEUE_DEPTH-1:0] entry_live;

  always_comb begin
    for (int e = 0; e < QUEUE_DEPTH; e++) begin
      int unsigned r_f;
      int unsigned b_f;
      r_f = int'(q_rank[e*RANK_W +: RANK_W]);
      b_f = int'(q_bank[e*BANK_W +: BANK_W]);
      entry_idx[e]  = efb_flat_index(r_f, b_f, BANKS_PER_RANK);
      entry_live[e] = q_valid[e] && (r_f < NUM_RANKS) && (b_f < BANKS_PER_RANK);
    end
  end

  // OR-reduce every live entry onto its bank.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic hit;
      hit = 1'b0;
      for (int e = 0; e < QUEUE_DEPTH; e++) begin
        if (entry_live[e] && (entry_idx[e] == b)) hit = 1'b1;
      end
      bank_waiting[b] = hit;
    end
  end

endmodule

// File: rtl/efb_min_scan.sv
module efb_min_scan #(
  parameter int unsigned NUM_BANKS  = 16,
  parameter int unsigned TIME_W     = 16,
  parameter int unsigned SCAN_STYLE = 1,
  localparam int unsigned LEAF_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0,
  localparam int unsigned LEAVES    = 1 << LEAF_W,
  localparam int unsigned NODES     = 2 * LEAVES - 1
) (
  input  logic [NUM_BANKS*TIME_W-1:0] bank_ready_time,
  input  logic [NUM_BANKS-1:0]        bank_waiting,
  output logic [NUM_BANKS-1:0]        scan_mask,
  output logic [TIME_W-1:0]           scan_min
);

  localparam logic [TIME_W-1:0] T_MAX = '1;

  function automatic logic [TIME_W-1:0] t_lesser(input logic [TIME_W-1:0] a,
                                                  input logic [TIME_W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  logic [TIME_W-1:0] bank_t [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_split
    assign bank_t[b] = bank_ready_time[b*TIME_W +: TIME_W];
  end

  if (SCAN_STYLE == 0) begin : g_linear
    // Ordered walk: a strictly earlier bank restarts the mask, an equal one joins it.
    always_comb begin
      logic [NUM_BANKS-1:0] run_mask;
      logic [TIME_W-1:0]    run_min;
      run_mask = '0;
      run_min  = T_MAX;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_waiting[b]) begin
          if (bank_t[b] < run_min) begin
            run_mask    = '0;
            run_mask[b] = 1'b1;
            run_min     = bank_t[b];
          end else if (bank_t[b] == run_min) begin
            run_mask[b] = 1'b1;
          end
        end
      end
      scan_mask = run_mask;
      scan_min  = run_min;
    end
  end else begin : g_tree
    // Pass one: minimum tree over masked leaves. Pass two: equality compare.
    logic [TIME_W-1:0] node [NODES];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
      if (l < NUM_BANKS) begin : g_real
        assign node[LEAVES-1+l] = bank_waiting[l] ? bank_t[l] : T_MAX;
      end else begin : g_pad
        assign node[LEAVES-1+l] = T_MAX;
      end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
      assign node[k] = t_lesser(node[2*k+1], node[2*k+2]);
    end

    assign scan_min = node[0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_eq
      assign scan_mask[b] = bank_waiting[b] && (bank_t[b] == node[0]);
    end
  end

endmodule

// File: rtl/efb_out_stage.sv
module efb_out_stage #(
  parameter int unsigned MASK_W  = 64,
  parameter int unsigned TIME_W  = 16,
  parameter int unsigned LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [TIME_W-1:0] in_min,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  output logic [TIME_W-1:0] out_min
);

  if (LATENCY == 0) begin : g_comb
    assign out_valid = in_valid;
    assign out_mask  = in_mask;
    assign out_min   = in_min;
  end else begin : g_pipe
    logic              stg_v [LATENCY];
    logic [MASK_W-1:0] stg_m [LATENCY];
    logic [TIME_W-1:0] stg_t [LATENCY];

    // Each stage loads only when the stage before it holds a fresh result.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < LATENCY; s++) begin
          stg_v[s] <= 1'b0;
          stg_m[s] <= '0;
          stg_t[s] <= '1;
        end
      end else begin
        stg_v[0] <= in_valid;
        if (in_valid) begin
          stg_m[0] <= in_mask;
          stg_t[0] <= in_min;
        end
        for (int s = 1; s < LATENCY; s++) begin
          stg_v[s] <= stg_v[s-1];
          if (stg_v[s-1]) begin
            stg_m[s] <= stg_m[s-1];
            stg_t[s] <= stg_t[s-1];
          end
        end
      end
    end

    assign out_valid = stg_v[LATENCY-1];
    assign out_mask  = stg_m[LATENCY-1];
    assign out_min   = stg_t[LATENCY-1];
  end

endmodule

// File: rtl/efb_earliest_bank_mask.sv
module efb_earliest_bank_mask #(
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 8,
  parameter int unsigned TIME_W         = 16,
  parameter int unsigned QUEUE_DEPTH    = 8,
  parameter int unsigned LATENCY        = 1,
  parameter int unsigned SCAN_STYLE     = 1,
  localparam int unsigned NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
  localparam int unsigned RANK_W        = efb_pkg::efb_idx_w(NUM_RANKS),
  localparam int unsigned BANK_W        = efb_pkg::efb_idx_w(BANKS_PER_RANK),
  localparam int unsigned MASK_W        = efb_pkg::EFB_MASK_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [NUM_BANKS*TIME_W-1:0]   bank_ready_time,
  input  logic [QUEUE_DEPTH-1:0]        q_valid,
  input  logic [QUEUE_DEPTH*RANK_W-1:0] q_rank,
  input  logic [QUEUE_DEPTH*BANK_W-1:0] q_bank,
  output logic                          out_valid,
  output logic [MASK_W-1:0]             out_mask,
  output logic [TIME_W-1:0]             out_min
);

  if (NUM_BANKS > MASK_W || NUM_BANKS == 0) begin : g_bad_shape
    $error("efb_earliest_bank_mask: bank count must be 1..64");
  end

  // Named internal events, visible to the bound checker.
  logic [NUM_BANKS-1:0] bank_waiting;
  logic [NUM_BANKS-1:0] scan_mask_n;
  logic [MASK_W-1:0]    scan_mask;
  logic [TIME_W-1:0]    scan_min;

  efb_waiting_map #(
    .NUM_RANKS      (NUM_RANKS),
    .BANKS_PER_RANK (BANKS_PER_RANK),
    .QUEUE_DEPTH    (QUEUE_DEPTH),
    .RANK_W         (RANK_W),
    .BANK_W         (BANK_W)
  ) u_wait (
    .q_valid      (q_valid),
    .q_rank       (q_rank),
    .q_bank       (q_bank),
    .bank_waiting (bank_waiting)
  );

  efb_min_scan #(
    .NUM_BANKS  (NUM_BANKS),
    .TIME_W     (TIME_W),
    .SCAN_STYLE (SCAN_STYLE)
  ) u_scan (
    .bank_ready_time (bank_ready_time),
    .bank_waiting    (bank_waiting),
    .scan_mask       (scan_mask_n),
    .scan_min        (scan_min)
  );

  assign scan_mask = MASK_W'(scan_mask_n);

  efb_out_stage #(
    .MASK_W  (MASK_W),
    .TIME_W  (TIME_W),
    .LATENCY (LATENCY)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mask   (scan_mask),
    .in_min    (scan_min),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_min   (out_min)
  );

endmodule

// File: rtl/efb_checker.sv
module efb_checker #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned TIME_W    = 16,
  parameter int unsigned LATENCY   = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        out_valid,
  input logic [63:0]                 out_mask,
  input logic [TIME_W-1:0]           out_min,
  input logic [NUM_BANKS*TIME_W-1:0] bank_ready_time,
  input logic [NUM_BANKS-1:0]        bank_waiting,
  input logic [63:0]                 scan_mask,
  input logic [TIME_W-1:0]           scan_min
);

  logic [63:0] wait_w;
  assign wait_w = 64'(bank_waiting);

  // R1: no mask bit outside the waiting set
  p_mask_waiting_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mask & ~wait_w) == 64'd0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // R3: a set bit carries the minimum time
    p_tie_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mask[b] |-> (bank_ready_time[b*TIME_W +: TIME_W] == scan_min));
    // R3: every waiting bank at the minimum is reported
    p_tie_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_waiting[b] && (bank_ready_time[b*TIME_W +: TIME_W] == scan_min))
        |-> scan_mask[b]);
    // R4: nothing waiting lies below the minimum
    p_min_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_waiting[b] |-> (bank_ready_time[b*TIME_W +: TIME_W] >= scan_min));
  end

  // R4: a non-empty waiting set yields a non-empty mask
  p_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_waiting != '0) |-> (scan_mask != 64'd0));

  // R5: empty waiting set
  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_waiting == '0) |-> ((scan_mask == 64'd0) && (scan_min == {TIME_W{1'b1}})));

  // R6: bits past the bank count stay clear
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mask >> NUM_BANKS) == 64'd0);

  if (LATENCY == 0) begin : g_lat0
    // R7: same-cycle result
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (out_mask == scan_mask));
  end else begin : g_latn
    logic [LATENCY-1:0] vshift;
    always_ff @(posedge clk) begin
      if (!rst_n) vshift <= '0;
      else        vshift <= {vshift, in_valid};
    end
    // R7: valid delayed by the declared latency
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vshift[LATENCY-1]);
    // R8: outputs hold when no new result arrives
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_mask) && $stable(out_min)));
    // R8: reset state visible right after reset release
    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && (out_mask == 64'd0) && (out_min == {TIME_W{1'b1}})));
  end

endmodule

bind efb_earliest_bank_mask efb_checker #(
  .NUM_BANKS (NUM_BANKS),
  .TIME_W    (TIME_W),
  .LATENCY   (LATENCY)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .out_valid       (out_valid),
  .out_mask        (out_mask),
  .out_min         (out_min),
  .bank_ready_time (bank_ready_time),
  .bank_waiting    (bank_waiting),
  .scan_mask       (scan_mask),
  .scan_min        (scan_min)
);

// File: tb/tb_efb_earliest_bank_mask.sv
`timescale 1ns/1ps
module tb_efb_earliest_bank_mask;

  localparam int NV = 7;
  localparam logic [127:0] T0 = 128'hF0E0_D0C0_B0A0_9080_7060_5040_3020_1000;
  localparam logic [127:0] T1 = 128'h4040_4040_4020_4040_2040_4040_4020_4040;
  localparam logic [127:0] T2 = 128'h0010_2030_4050_6070_8090_A0B0_C0D0_E0F0;
  localparam logic [127:0] TF = {128{1'b1}};

  // Entry ids packed as {e3,e2,e1,e0}, each nibble {rank, bank[2:0]}.
  localparam logic [127:0] VT [NV] = '{T0, T0, T1, T1, T0, TF, T2};
  localparam logic [3:0]   VV [NV] = '{4'hF, 4'h9, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF};
  localparam logic [15:0]  VQ [NV] = '{16'h935C, 16'h935C, 16'hA721, 16'hA211,
                                       16'h935C, 16'hFF00, 16'hE810};
  localparam logic [63:0]  VM [NV] = '{64'h8, 64'h200, 64'h484, 64'h404,
                                       64'h0, 64'h8001, 64'h4000};
  localparam logic [7:0]   VN [NV] = '{8'h30, 8'h90, 8'h20, 8'h20, 8'hFF, 8'hFF, 8'h10};
  localparam string        VR [NV] = '{"R2", "R9", "R3", "R1", "R5", "R3", "R4"};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] times = '0;
  logic [3:0]   qv = '0;
  logic [3:0]   qr = '0;
  logic [11:0]  qb = '0;
  logic         o_v, c_v;
  logic [63:0]  o_m, c_m;
  logic [7:0]   o_t, c_t;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  efb_earliest_bank_mask #(.NUM_RANKS(2), .BANKS_PER_RANK(8), .TIME_W(8),
    .QUEUE_DEPTH(4), .LATENCY(1), .SCAN_STYLE(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_ready_time(times),
    .q_valid(qv), .q_rank(qr), .q_bank(qb),
    .out_valid(o_v), .out_mask(o_m), .out_min(o_t));

  efb_earliest_bank_mask #(.NUM_RANKS(2), .BANKS_PER_RANK(8), .TIME_W(8),
    .QUEUE_DEPTH(4), .LATENCY(0), .SCAN_STYLE(0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_ready_time(times),
    .q_valid(qv), .q_rank(qr), .q_bank(qb),
    .out_valid(c_v), .out_mask(c_m), .out_min(c_t));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [127:0] t, input logic [3:0] v, input logic [15:0] ids);
    times = t;
    qv    = v;
    for (int e = 0; e < 4; e++) begin
      qr[e]        = ids[4*e+3];
      qb[3*e +: 3] = ids[4*e +: 3];
    end
  endtask

  // Reference: a waiting bank is earliest when no waiting bank is strictly earlier.
  task automatic ref_eval(input logic [127:0] t, input logic [3:0] v, input logic [15:0] ids,
                          output logic [63:0] m, output logic [7:0] mn);
    logic [15:0] w;
    w  = '0;
    m  = '0;
    mn = 8'hFF;
    for (int e = 0; e < 4; e++) if (v[e]) w[ids[4*e +: 4]] = 1'b1;
    for (int b = 0; b < 16; b++) begin
      if (w[b]) begin
        logic earliest;
        earliest = 1'b1;
        for (int c = 0; c < 16; c++)
          if (w[c] && (t[8*c +: 8] < t[8*b +: 8])) earliest = 1'b0;
        m[b] = earliest;
      end
    end
    for (int b = 0; b < 16; b++) if (m[b]) mn = t[8*b +: 8];
  endtask

  initial begin
    logic [31:0]  lfsr;
    logic [127:0] rt;
    logic [15:0]  rid;
    logic [3:0]   rv;
    logic [63:0]  em;
    logic [7:0]   en;

    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset valid", 64'(o_v), 64'd0);
    chk("R8 reset mask", o_m, 64'd0);
    chk("R8 reset min", 64'(o_t), 64'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: nothing appears before the clock edge
    in_valid = 1'b1;
    drive(VT[0], VV[0], VQ[0]);
    #1;
    chk("R7 not early", 64'(o_v), 64'd0);
    chk("R7 comb same cycle", c_m, VM[0]);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) begin
        @(negedge clk);
        drive(VT[i], VV[i], VQ[i]);
      end
      @(negedge clk);
      chk({VR[i], " valid"}, 64'(o_v), 64'd1);
      chk({VR[i], " mask"}, o_m, VM[i]);
      chk({VR[i], " min"}, 64'(o_t), 64'(VN[i]));
      chk("R10 comb mask", c_m, VM[i]);
      chk("R10 comb min", 64'(c_t), 64'(VN[i]));
      if (i == 5) chk("R6 upper bits", o_m >> 16, 64'd0);
    end

    // R8: hold with in_valid low while inputs change
    in_valid = 1'b0;
    drive(T0, 4'hF, 16'h0123);
    @(negedge clk);
    chk("R7 valid drops", 64'(o_v), 64'd0);
    chk("R8 hold mask", o_m, VM[NV-1]);
    chk("R8 hold min", 64'(o_t), 64'(VN[NV-1]));
    chk("R7 comb valid", 64'(c_v), 64'd0);

    // R3/R4: pseudo-random patterns with many ties
    lfsr = 32'h1D2C_3B4A;
    in_valid = 1'b1;
    for (int k = 0; k < 24; k++) begin
      for (int b = 0; b < 16; b++) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        rt[8*b +: 8] = {4'h0, lfsr[3:0]};
      end
      rid = lfsr[31:16];
      rv  = lfsr[7:4];
      ref_eval(rt, rv, rid, em, en);
      drive(rt, rv, rid);
      @(negedge clk);
      chk("R3 rand mask", o_m, em);
      chk("R4 rand min", 64'(o_t), 64'(en));
      chk("R10 rand comb", c_m, em);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule